// File: doc/BRIEF.md
# Bit-Serial Ternary Match Array

This block holds a set of ternary words, each bit stored as a two-bit code for 0, 1 or don't-care. It compares a search key against all of them. The key is taken one bit position per step, least significant bit first. Every word has its own running match flag, and the words are evaluated side by side within each step. Each step has two cycles. In the prepare cycle, the cell at the current bit position of every live word is loaded into that word's column register. In the decide cycle, the loaded cell is compared with the key bit and the result is folded into the word's flag.

A word whose flag has dropped is in standby. Its column register is no longer loaded and its flag is no longer updated, so it costs no switching for the rest of the search. After the last decide cycle the block presents the per-word result vector together with a one-cycle completion strobe. The live-word mask and the number of live words are visible on every cycle. A sleep input freezes the block. While sleep is high, the stored words, the search state and the outputs all stay as they are, and writes and search requests are refused. A search made after sleep therefore gives the same answer as before sleep.

Top module: `tcam_bitserial`

## Requirements
- R1: A cell code is written as {hi,lo}, where hi comes from `wr_hi` and lo from `wr_lo` at the same bit position. {0,0} is don't-care and matches either key bit. {1,0} holds a 1 and matches only a key bit of 1. {0,1} holds a 0 and matches only a key bit of 0. {1,1} is invalid and never matches. A word's bit in `match_vec` is 1 only if every one of its cells matches the key.
- R2: A `start` sampled while idle and not asleep is accepted. `done` is then high during the cycle after the 2*WIDTH-th rising edge that follows the accepting edge, and only for that one cycle.
- R3: `match_vec` is cleared to zero at the accepting edge. It stays zero until the edge that raises `done`, takes the search result at that edge, and then holds it until the next search is accepted.
- R4: At the accepting edge every word becomes active. Bit b (LSB first) is decided at rising edge 2*(b+1) after the accepting edge. A word's `active_vec` bit falls at the decision of its first mismatching bit. During a search, no bit of `active_vec` ever rises.
- R5: `active_cnt` always equals the number of ones in `active_vec`.
- R6: A write requested while a search is in progress is ignored, and the stored word is left unchanged.
- R7: A `start` raised while a search is in progress is ignored. Neither the result nor the completion time changes.
- R8: While `sleep` is high, writes and `start` are ignored and the search makes no progress. `active_vec`, `active_cnt`, `match_vec` and the stored words all hold. Once sleep is released, a search returns the same result it would have returned before sleep.
- R9: A write and a `start` sampled in the same idle cycle are both accepted, and the search that starts uses the newly written word.
- R10: After reset, `done`, `match_vec`, `active_vec` and `active_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Freeze request; state and contents are retained |
| wr_en | input | 1 | Write request for one word |
| wr_addr | input | AW | Index of the word to write |
| wr_hi | input | WIDTH | High bit of each cell code |
| wr_lo | input | WIDTH | Low bit of each cell code |
| start | input | 1 | Search request; key is sampled with it |
| key | input | WIDTH | Search key |
| match_vec | output | WORDS | Per-word search result |
| done | output | 1 | One-cycle completion strobe |
| active_vec | output | WORDS | Per-word active (1) or standby (0) |
| active_cnt | output | CW | Number of active words |

## Verification
A write and a search request can land in the same cycle. When the block is idle, a write issued together with `start` must be taken and must be visible to that same search. The bench provokes this by driving both on one cycle, with a key that matches only the newly written value of the target word. The result vector then shows whether the old or the new contents were searched. The reverse case is also provoked: a write and a second `start` issued in the middle of a search. Here the result, the completion cycle and a follow-up search must all show that neither request was taken.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PREP = 2'd1,
    PH_DECIDE = 2'd2
  } phase_e;

  // Cell code {hi,lo}: 00 any, 10 one, 01 zero, 11 invalid.
  function automatic logic cell_hit(input logic hi, input logic lo, input logic kbit);
    logic r;
    unique case ({hi, lo})
      2'b00:   r = 1'b1;
      2'b10:   r = kbit;
      2'b01:   r = ~kbit;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tcam_seq.sv
module tcam_seq
  import tcam_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep,
  input  logic          start,
  input  logic [WIDTH-1:0] key,
  output logic          busy,
  output logic          accept,
  output logic          prep_fire,
  output logic          decide_fire,
  output logic          last_decide,
  output logic [BW-1:0] bit_idx,
  output logic          key_bit
);

  localparam logic [BW-1:0] LAST = BW'(WIDTH - 1);

  phase_e            phase_q;
  logic [BW-1:0]     bit_q;
  logic [WIDTH-1:0]  key_q;

  assign busy        = (phase_q != PH_IDLE);
  assign accept      = (phase_q == PH_IDLE) && start && !sleep;
  assign prep_fire   = (phase_q == PH_PREP) && !sleep;
  assign decide_fire = (phase_q == PH_DECIDE) && !sleep;
  assign last_decide = decide_fire && (bit_q == LAST);
  assign bit_idx     = bit_q;
  assign key_bit     = key_q[bit_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      key_q   <= '0;
    end else if (!sleep) begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            key_q   <= key;
            bit_q   <= '0;
            phase_q <= PH_PREP;
          end
        end
        PH_PREP: phase_q <= PH_DECIDE;
        PH_DECIDE: begin
          if (bit_q == LAST) begin
            phase_q <= PH_IDLE;
          end else begin
            bit_q   <= bit_q + 1'b1;
            phase_q <= PH_PREP;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int WORDS = 8,
  parameter int WIDTH = 8,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ok,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_hi,
  input  logic [WIDTH-1:0] wr_lo,
  input  logic             rd_en,
  input  logic [BW-1:0]    bit_idx,
  input  logic [WORDS-1:0] live,
  output logic [WORDS-1:0] col_hi,
  output logic [WORDS-1:0] col_lo
);

  // Two bit planes; contents are not touched by reset (retention).
  logic [WIDTH-1:0] hi_mem [WORDS];
  logic [WIDTH-1:0] lo_mem [WORDS];

  logic addr_ok;
  assign addr_ok = ({1'b0, wr_addr} < (AW + 1)'(WORDS));

  always_ff @(posedge clk) begin
    if (wr_ok && addr_ok) begin
      hi_mem[wr_addr] <= wr_hi;
      lo_mem[wr_addr] <= wr_lo;
    end
  end

  // Per-word column register; a standby word keeps its last value.
  for (genvar w = 0; w < WORDS; w++) begin : g_col
    always_ff @(posedge clk) begin
      if (rst) begin
        col_hi[w] <= 1'b0;
        col_lo[w] <= 1'b0;
      end else if (rd_en && live[w]) begin
        col_hi[w] <= hi_mem[w][bit_idx];
        col_lo[w] <= lo_mem[w][bit_idx];
      end
    end
  end

endmodule

// File: rtl/tcam_acc.sv
module tcam_acc
  import tcam_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int CW = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             decide,
  input  logic             key_bit,
  input  logic [WORDS-1:0] col_hi,
  input  logic [WORDS-1:0] col_lo,
  output logic [WORDS-1:0] acc,
  output logic [WORDS-1:0] acc_nxt,
  output logic [CW-1:0]    cnt
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_comb begin
      if (clear) begin
        acc_nxt[w] = 1'b1;
      end else if (decide && acc[w]) begin
        acc_nxt[w] = cell_hit(col_hi[w], col_lo[w], key_bit);
      end else begin
        acc_nxt[w] = acc[w];
      end
    end
  end

  logic [CW-1:0] cnt_nxt;
  always_comb begin
    cnt_nxt = '0;
    for (int i = 0; i < WORDS; i++) begin
      cnt_nxt = cnt_nxt + CW'(acc_nxt[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      cnt <= '0;
    end else begin
      acc <= acc_nxt;
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/tcam_bitserial.sv
module tcam_bitserial #(
  parameter int WORDS = 8,
  parameter int WIDTH = 8,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int CW = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_hi,
  input  logic [WIDTH-1:0] wr_lo,
  input  logic             start,
  input  logic [WIDTH-1:0] key,
  output logic [WORDS-1:0] match_vec,
  output logic             done,
  output logic [WORDS-1:0] active_vec,
  output logic [CW-1:0]    active_cnt
);

  logic          busy;
  logic          accept;
  logic          prep_fire;
  logic          decide_fire;
  logic          last_decide;
  logic [BW-1:0] bit_idx;
  logic          key_bit;
  logic          wr_ok;

  logic [WORDS-1:0] col_hi;
  logic [WORDS-1:0] col_lo;
  logic [WORDS-1:0] acc;
  logic [WORDS-1:0] acc_nxt;
  logic [CW-1:0]    cnt;

  assign wr_ok = wr_en && !busy && !sleep;

  tcam_seq #(.WIDTH(WIDTH)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .sleep       (sleep),
    .start       (start),
    .key         (key),
    .busy        (busy),
    .accept      (accept),
    .prep_fire   (prep_fire),
    .decide_fire (decide_fire),
    .last_decide (last_decide),
    .bit_idx     (bit_idx),
    .key_bit     (key_bit)
  );

  tcam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_ok   (wr_ok),
    .wr_addr (wr_addr),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .rd_en   (prep_fire),
    .bit_idx (bit_idx),
    .live    (acc),
    .col_hi  (col_hi),
    .col_lo  (col_lo)
  );

  tcam_acc #(.WORDS(WORDS)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .decide  (decide_fire),
    .key_bit (key_bit),
    .col_hi  (col_hi),
    .col_lo  (col_lo),
    .acc     (acc),
    .acc_nxt (acc_nxt),
    .cnt     (cnt)
  );

  logic [WORDS-1:0] match_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_decide;
      if (accept) begin
        match_q <= '0;
      end else if (last_decide) begin
        match_q <= acc_nxt;
      end
    end
  end

  assign match_vec  = match_q;
  assign done       = done_q;
  assign active_vec = acc;
  assign active_cnt = cnt;

endmodule

// File: rtl/tcam_bitserial_chk.sv
module tcam_bitserial_chk #(
  parameter int WORDS = 8,
  parameter int CW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sleep,
  input logic             busy,
  input logic             done,
  input logic [WORDS-1:0] match_vec,
  input logic [WORDS-1:0] active_vec,
  input logic [CW-1:0]    active_cnt
);

  // R2: completion strobe lasts one cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: result only moves on completion or on acceptance of a search
  p_match_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!done && !$rose(busy)) |-> $stable(match_vec));

  // R4: no word returns from standby inside a search
  p_no_revive_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((active_vec & ~$past(active_vec)) == '0));

  // R4: a reported match belongs to a word still active at completion
  p_match_live_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (match_vec == active_vec));

  // R5: live count agrees with the live mask
  p_count_r5: assert property (@(posedge clk) disable iff (rst)
    active_cnt == CW'($countones(active_vec)));

  // R8: sleep freezes the visible state
  p_sleep_hold_r8: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(active_vec) && $stable(active_cnt) && $stable(match_vec)));

endmodule

bind tcam_bitserial tcam_bitserial_chk #(.WORDS(WORDS), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sleep      (sleep),
  .busy       (busy),
  .done       (done),
  .match_vec  (match_vec),
  .active_vec (active_vec),
  .active_cnt (active_cnt)
);

// File: tb/tb_tcam_bitserial.sv
module tb_tcam_bitserial;

  localparam int N  = 8;
  localparam int W  = 8;
  localparam int AW = 3;
  localparam int CW = 4;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst;
  logic          sleep;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [W-1:0]  wr_hi;
  logic [W-1:0]  wr_lo;
  logic          start;
  logic [W-1:0]  key;
  logic [N-1:0]  match_vec;
  logic          done;
  logic [N-1:0]  active_vec;
  logic [CW-1:0] active_cnt;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_hi [N];
  logic [W-1:0] m_lo [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tcam_bitserial #(.WORDS(N), .WIDTH(W)) dut (
    .clk(clk), .rst(rst), .sleep(sleep), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .start(start), .key(key),
    .match_vec(match_vec), .done(done), .active_vec(active_vec),
    .active_cnt(active_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic hit(input logic hi, input logic lo, input logic kb);
    if (hi && lo) return 1'b0;
    if (!hi && !lo) return 1'b1;
    return hi ? kb : ~kb;
  endfunction

  // words still live after nb bits have been decided
  function automatic logic [N-1:0] exp_live(input logic [W-1:0] k, input int nb);
    logic [N-1:0] r;
    for (int w = 0; w < N; w++) begin
      r[w] = 1'b1;
      for (int b = 0; b < nb; b++) begin
        if (!hit(m_hi[w][b], m_lo[w][b], k[b])) r[w] = 1'b0;
      end
    end
    return r;
  endfunction

  function automatic int ones(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic put_word(input int a, input logic [W-1:0] val,
                          input logic [W-1:0] care, input logic [W-1:0] bad);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a);
    wr_hi = (val & care) | bad; wr_lo = (~val & care) | bad;
    m_hi[a] = wr_hi; m_lo[a] = wr_lo;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // mode: 0 plain, 1 write mid-search, 2 start mid-search,
  //       3 sleep mid-search, 4 write together with start
  task automatic run_search(input logic [W-1:0] k, input int mode);
    logic [N-1:0] exp_m;
    logic [N-1:0] held;
    @(negedge clk);
    start = 1'b1; key = k;
    if (mode == 4) begin
      wr_en = 1'b1; wr_addr = AW'(6); wr_hi = k; wr_lo = ~k;
      m_hi[6] = k; m_lo[6] = ~k;
    end
    exp_m = exp_live(k, W);
    for (int e = 0; e <= 2 * W; e++) begin
      @(posedge clk); @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
      chk(active_vec == exp_live(k, e / 2), "R4", "active mask", 32'(active_vec), 32'(exp_live(k, e / 2)));
      chk(int'(active_cnt) == ones(active_vec), "R5", "active count", 32'(active_cnt), 32'(ones(active_vec)));
      chk(done == (e == 2 * W), "R2", "done timing", 32'(done), 32'(e == 2 * W));
      if (e < 2 * W)
        chk(match_vec == '0, "R3", "result cleared in search", 32'(match_vec), 32'h0);
      else
        chk(match_vec == exp_m, "R1", "match result", 32'(match_vec), 32'(exp_m));
      if (e == 2 && mode == 1) begin
        wr_en = 1'b1; wr_addr = '0; wr_hi = 8'h00; wr_lo = 8'hFF;
      end
      if (e == 2 && mode == 2) begin
        start = 1'b1; key = ~k;
      end
      if (e == 2 && mode == 3) begin
        held = active_vec;
        sleep = 1'b1;
        for (int s = 0; s < 4; s++) begin
          @(posedge clk); @(negedge clk);
          chk(active_vec == held && !done, "R8", "frozen while asleep", 32'(active_vec), 32'(held));
        end
        sleep = 1'b0;
      end
    end
    @(posedge clk); @(negedge clk);
    chk(!done, "R2", "done is one cycle", 32'(done), 32'h0);
    chk(match_vec == exp_m, "R3", "result held", 32'(match_vec), 32'(exp_m));
  endtask

  task automatic t_reset;
    chk(!done, "R10", "done after reset", 32'(done), 0);
    chk(match_vec == '0, "R10", "match after reset", 32'(match_vec), 0);
    chk(active_vec == '0, "R10", "active after reset", 32'(active_vec), 0);
    chk(active_cnt == '0, "R10", "count after reset", 32'(active_cnt), 0);
  endtask

  task automatic t_load;
    put_word(0, 8'h00, 8'h00, 8'h00);   // all don't-care
    put_word(1, 8'hA5, 8'hFF, 8'h00);
    put_word(2, 8'hA5, 8'hF0, 8'h00);
    put_word(3, 8'h00, 8'h00, 8'h20);   // invalid cell at bit 5
    put_word(4, 8'h5A, 8'hFF, 8'h00);
    put_word(5, 8'h25, 8'hFF, 8'h00);   // differs from A5 at bit 7
    put_word(6, 8'h00, 8'hFF, 8'h00);
    put_word(7, 8'hFF, 8'hFF, 8'h00);
  endtask

  task automatic t_patterns;   // R1 R2 R4 R5
    run_search(8'hA5, 0);
    run_search(8'h00, 0);
    run_search(8'hFF, 0);
    run_search(8'h5A, 0);
    run_search(8'hB5, 0);
  endtask

  task automatic t_write_busy;   // R6
    run_search(8'hA5, 1);
    run_search(8'hA5, 0);        // word 0 must still be all don't-care
  endtask

  task automatic t_start_busy;   // R7
    run_search(8'h5A, 2);
  endtask

  task automatic t_collide;      // R9
    run_search(8'h3C, 4);
    chk(match_vec[6], "R9", "same-cycle write seen", 32'(match_vec[6]), 1);
  endtask

  task automatic t_sleep;        // R8
    logic [N-1:0] av;
    logic [N-1:0] mv;
    run_search(8'hA5, 0);
    av = active_vec; mv = match_vec;
    @(negedge clk);
    sleep = 1'b1; wr_en = 1'b1; wr_addr = AW'(1); wr_hi = 8'h00; wr_lo = 8'hFF;
    start = 1'b1; key = 8'h00;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk(!done && active_vec == av && match_vec == mv, "R8", "requests refused asleep", 32'(active_vec), 32'(av));
    end
    wr_en = 1'b0; start = 1'b0; sleep = 1'b0;
    @(negedge clk);
    chk(active_vec == av && !done, "R8", "no start after wake", 32'(active_vec), 32'(av));
    run_search(8'hA5, 0);
    chk(match_vec == mv, "R8", "same result after wake", 32'(match_vec), 32'(mv));
    run_search(8'hA5, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; sleep = 1'b0; wr_en = 1'b0; wr_addr = '0;
    wr_hi = '0; wr_lo = '0; start = 1'b0; key = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_patterns();
    t_write_busy();
    t_start_busy();
    t_collide();
    t_sleep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule